// File: doc/BRIEF.md
# Supervisory Fault Filter and Auto-Restart Sequencer

This block supervises a switching power controller. It watches the supply comparators, the output-voltage samples taken once per switching cycle, the line-sense flag, a temperature alarm and an abnormal-overcurrent alarm. It decides when the power switch may run and when the high-voltage startup source charges the supply capacitor. Each fault is filtered either by time (in clock cycles) or by a count of consecutive switching cycles. After a fault the block runs auto-restart hiccups: switching stays off, and the supply is allowed to fall to the turn-off threshold and climb back to the turn-on threshold one or more times before a new start is attempted.

Faults on the output voltage lead to a longer quiet period. Its length in hiccups depends on the line mode captured when the fault trips. All other faults lead to a single hiccup. When several faults trip in the same cycle, a fixed priority selects the one that sets the hiccup budget. No fault latches the block off.

Top module: `fault_restart_seq`

## Requirements
- R1: While reset is asserted and just after it, switching is disabled (`sw_en`=0) and the startup source is enabled (`hv_src_en`=1). The two outputs are never both 1.
- R2: From the charging state, one cycle of `vdd_above_on` moves the block to the brown-in check, and `hv_src_en` stays 1 there. If `line_ok`=1 at the next edge, `sw_en` becomes 1 and `hv_src_en` becomes 0 on that edge.
- R3: If `line_ok`=0 during the brown-in check, the block enters a single-hiccup auto-restart: both outputs go to 0.
- R4: `vdd_over` held high for SUPPLY_OV_CYC consecutive clocks while running stops switching on the last of those clocks. A shorter high interval has no effect.
- R5: `out_ov_smp`=1 on OUT_OV_CNT consecutive `cycle_end` strobes trips the block. A strobe with `out_ov_smp`=0 restarts the count.
- R6: `out_uv_smp`=1 on OUT_UV_CNT consecutive strobes trips the block. This check is ignored for the first UV_BLANK_CYC clocks after each entry into running.
- R7: After an output over- or under-voltage trip, a new start takes HIC_LOW_LINE turn-off crossings when `high_line`=0 at the trip, and HIC_HIGH_LINE crossings when `high_line`=1. A later change of `high_line` does not alter the count.
- R8: After any other trip, the first `vdd_below_off` returns the block to charging (`hv_src_en`=1), and the next `vdd_above_on` restarts it normally. During a hiccup, `vdd_above_on` turns the source off again without starting.
- R9: `temp_hot` or `ocp_abn` high while running stops switching on the next clock edge.
- R10: `line_ok` low for BO_WINDOW_CYC consecutive clocks trips the block if a strobe occurred in that window. If no strobe occurred, the block trips on the BO_RECHECK_CNT-th strobe with `line_ok` low after the window. `line_ok` returning high restarts the measurement.
- R11: Trip priority, from highest to lowest, is over-temperature, abnormal overcurrent, supply overvoltage, output-voltage fault, brown-out. The selected cause sets the hiccup budget.
- R12: `vdd_below_off` while running, with no fault, disables switching and re-enables the startup source on the next edge, with no hiccup budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_above_on | input | 1 | Supply has reached the turn-on threshold |
| vdd_below_off | input | 1 | Supply has fallen to the turn-off threshold |
| vdd_over | input | 1 | Supply above its overvoltage threshold |
| cycle_end | input | 1 | One-clock strobe at the end of each switching cycle |
| out_ov_smp | input | 1 | Sampled output above its overvoltage level, valid with `cycle_end` |
| out_uv_smp | input | 1 | Sampled output below its undervoltage level, valid with `cycle_end` |
| line_ok | input | 1 | Line sense above the brown-in/brown-out level |
| temp_hot | input | 1 | Die over-temperature alarm |
| ocp_abn | input | 1 | Abnormal overcurrent seen in the present cycle |
| high_line | input | 1 | Line mode: 1 high line, 0 low line |
| sw_en | output | 1 | Switching permitted |
| hv_src_en | output | 1 | High-voltage startup source enabled |

## Verification
The hardest situation to reach is the brown-out recheck. The line-sense flag must stay low through a full window with no switching strobes at all, and only afterwards do strobes arrive. The stimulus produces this by holding `line_ok` low while sending no `cycle_end`, and then counting strobes across the recheck threshold. A second hard case is two faults of different priority tripping on the same edge. The bench lines up the last qualifying output-voltage strobe with a temperature alarm and then counts hiccups to observe which cause won. Randomised over- and under-voltage sample patterns with a random line mode cover the consecutive-count resets and both hiccup budgets.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_CHARGE,
    ST_BROWNIN_CHECK,
    ST_RUN,
    ST_FAULT_DISCHARGE,
    ST_HICCUP_WAIT
  } frs_state_e;

  typedef enum logic [2:0] {
    FC_NONE,
    FC_OVERTEMP,
    FC_OVERCUR,
    FC_SUPPLY_OV,
    FC_OUTPUT,
    FC_BROWNOUT
  } frs_cause_e;

  typedef struct packed {
    logic overtemp;
    logic overcur;
    logic supply_ov;
    logic output_v;
    logic brownout;
  } frs_faults_t;

  // fixed priority: temperature, overcurrent, supply OV, output, brown-out
  function automatic frs_cause_e frs_pick(input frs_faults_t f);
    if (f.overtemp)       return FC_OVERTEMP;
    else if (f.overcur)   return FC_OVERCUR;
    else if (f.supply_ov) return FC_SUPPLY_OV;
    else if (f.output_v)  return FC_OUTPUT;
    else if (f.brownout)  return FC_BROWNOUT;
    else                  return FC_NONE;
  endfunction

endpackage

// File: rtl/frs_time_filter.sv
module frs_time_filter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic level,
  output logic hit
);
  localparam int unsigned CW  = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr || !level) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != TOP) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = level && !clr && (cnt_q == TOP);

  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  generate
    if (LIMIT > 1) begin : g_hold
      // R4/R10: a hit needs the level already present on the previous edge
      a_r4_hit_after_level: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(level));
    end
  endgenerate

endmodule

// File: rtl/frs_cycle_filter.sv
module frs_cycle_filter #(
  parameter int unsigned COUNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic flag,
  output logic hit
);
  localparam int unsigned CW  = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] TOP = CW'(COUNT - 1);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;

  always_comb begin
    run_en = 1'b0;
    run_d  = run_q;
    if (clr) begin
      run_en = 1'b1;
      run_d  = '0;
    end else if (strobe) begin
      run_en = 1'b1;
      if (!flag)            run_d = '0;
      else if (run_q != TOP) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign hit = strobe && flag && !clr && (run_q == TOP);

  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= TOP);

  // R5: count is dropped whenever a clean sample is seen
  a_r5_clean_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !flag) |=> (run_q == '0));

endmodule

// File: rtl/frs_brownout.sv
module frs_brownout #(
  parameter int unsigned WINDOW  = 1650000,
  parameter int unsigned RECHECK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic line_ok,
  input  logic strobe,
  output logic trip
);
  localparam int unsigned RW   = (RECHECK > 1) ? $clog2(RECHECK) : 1;
  localparam logic [RW-1:0] RTOP = RW'(RECHECK - 1);

  logic win_clr, win_level, win_hit;
  logic gate_seen_q, gate_seen_d;
  logic [RW-1:0] rck_q, rck_d;
  logic          rck_en;

  assign win_clr   = !run;
  assign win_level = !line_ok;

  frs_time_filter #(.LIMIT(WINDOW)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_clr),
    .level (win_level),
    .hit   (win_hit)
  );

  always_comb begin
    gate_seen_d = gate_seen_q;
    rck_en      = 1'b0;
    rck_d       = rck_q;
    if (!run || line_ok) begin
      gate_seen_d = 1'b0;
      rck_en      = 1'b1;
      rck_d       = '0;
    end else begin
      if (strobe && !win_hit) gate_seen_d = 1'b1;
      if (win_hit && !gate_seen_q && strobe && (rck_q != RTOP)) begin
        rck_en = 1'b1;
        rck_d  = rck_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_seen_q <= 1'b0;
      rck_q       <= '0;
    end else begin
      gate_seen_q <= gate_seen_d;
      if (rck_en) rck_q <= rck_d;
    end
  end

  assign trip = win_hit && (gate_seen_q || (strobe && (rck_q == RTOP)));

  a_r10_trip_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (!line_ok && run));

  a_r10_recheck_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rck_q <= RTOP);

endmodule

// File: rtl/frs_restart_fsm.sv
module frs_restart_fsm
  import frs_pkg::*;
#(
  parameter int unsigned HIC_LL = 3,
  parameter int unsigned HIC_HL = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vdd_on,
  input  logic        vdd_off,
  input  logic        line_ok,
  input  logic        high_line,
  input  frs_faults_t faults,
  output logic        run,
  output logic        sw_en,
  output logic        hv_src_en
);
  localparam int unsigned HMAX = (HIC_HL > HIC_LL) ? HIC_HL : HIC_LL;
  localparam int unsigned HW   = $clog2(HMAX + 1);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [HW-1:0] H_LL  = HW'(HIC_LL);
  localparam logic [HW-1:0] H_HL  = HW'(HIC_HL);

  frs_state_e    state_q, state_d;
  logic [HW-1:0] hic_q, hic_d;
  logic          hic_en;
  frs_cause_e    cause;

  assign cause = frs_pick(faults);

  always_comb begin
    state_d = state_q;
    hic_en  = 1'b0;
    hic_d   = hic_q;
    unique case (state_q)
      ST_IDLE_CHARGE: begin
        if (vdd_on) state_d = ST_BROWNIN_CHECK;
      end
      ST_BROWNIN_CHECK: begin
        if (vdd_off) begin
          state_d = ST_IDLE_CHARGE;
        end else if (line_ok) begin
          state_d = ST_RUN;
        end else begin
          state_d = ST_FAULT_DISCHARGE;
          hic_en  = 1'b1;
          hic_d   = H_ONE;
        end
      end
      ST_RUN: begin
        if (cause != FC_NONE) begin
          state_d = ST_FAULT_DISCHARGE;
          hic_en  = 1'b1;
          if (cause == FC_OUTPUT) hic_d = high_line ? H_HL : H_LL;
          else                    hic_d = H_ONE;
        end else if (vdd_off) begin
          state_d = ST_IDLE_CHARGE;
        end
      end
      ST_FAULT_DISCHARGE: begin
        if (vdd_off) begin
          hic_en = 1'b1;
          if (hic_q <= H_ONE) begin
            state_d = ST_IDLE_CHARGE;
            hic_d   = '0;
          end else begin
            state_d = ST_HICCUP_WAIT;
            hic_d   = hic_q - 1'b1;
          end
        end
      end
      ST_HICCUP_WAIT: begin
        if (vdd_on) state_d = ST_FAULT_DISCHARGE;
      end
      default: state_d = ST_IDLE_CHARGE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE_CHARGE;
      hic_q   <= '0;
    end else begin
      state_q <= state_d;
      if (hic_en) hic_q <= hic_d;
    end
  end

  assign run       = (state_q == ST_RUN);
  assign sw_en     = run;
  assign hv_src_en = (state_q == ST_IDLE_CHARGE) || (state_q == ST_BROWNIN_CHECK) ||
                     (state_q == ST_HICCUP_WAIT);

  a_r1_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && hv_src_en));

  a_r2_start_via_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(state_q == ST_BROWNIN_CHECK) && $past(line_ok));

  a_r8_fault_never_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT_DISCHARGE) |=> (state_q != ST_RUN));

  a_r7_wait_has_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HICCUP_WAIT) |-> (hic_q != '0));

  a_r7_budget_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hic_q <= HW'(HMAX));

endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq
  import frs_pkg::*;
#(
  parameter int unsigned SUPPLY_OV_CYC  = 7000,
  parameter int unsigned OUT_OV_CNT     = 3,
  parameter int unsigned OUT_UV_CNT     = 3,
  parameter int unsigned UV_BLANK_CYC   = 4000000,
  parameter int unsigned BO_WINDOW_CYC  = 1650000,
  parameter int unsigned BO_RECHECK_CNT = 3,
  parameter int unsigned HIC_LOW_LINE   = 3,
  parameter int unsigned HIC_HIGH_LINE  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_above_on,
  input  logic vdd_below_off,
  input  logic vdd_over,
  input  logic cycle_end,
  input  logic out_ov_smp,
  input  logic out_uv_smp,
  input  logic line_ok,
  input  logic temp_hot,
  input  logic ocp_abn,
  input  logic high_line,
  output logic sw_en,
  output logic hv_src_en
);
  logic        run, idle_clr;
  logic        vovp_hit, ov_hit, uv_hit, bo_trip;
  logic        blank_done, uv_clr;
  frs_faults_t faults;

  assign idle_clr = !run;
  assign uv_clr   = !run || !blank_done;

  frs_time_filter #(.LIMIT(SUPPLY_OV_CYC)) u_vovp (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .level(vdd_over), .hit(vovp_hit)
  );

  frs_time_filter #(.LIMIT(UV_BLANK_CYC)) u_uv_blank (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .level(run), .hit(blank_done)
  );

  frs_cycle_filter #(.COUNT(OUT_OV_CNT)) u_out_ov (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .strobe(cycle_end),
    .flag(out_ov_smp), .hit(ov_hit)
  );

  frs_cycle_filter #(.COUNT(OUT_UV_CNT)) u_out_uv (
    .clk(clk), .rst_n(rst_n), .clr(uv_clr), .strobe(cycle_end),
    .flag(out_uv_smp), .hit(uv_hit)
  );

  frs_brownout #(.WINDOW(BO_WINDOW_CYC), .RECHECK(BO_RECHECK_CNT)) u_bo (
    .clk(clk), .rst_n(rst_n), .run(run), .line_ok(line_ok),
    .strobe(cycle_end), .trip(bo_trip)
  );

  always_comb begin
    faults.overtemp  = temp_hot;
    faults.overcur   = ocp_abn;
    faults.supply_ov = vovp_hit;
    faults.output_v  = ov_hit || uv_hit;
    faults.brownout  = bo_trip;
  end

  frs_restart_fsm #(.HIC_LL(HIC_LOW_LINE), .HIC_HL(HIC_HIGH_LINE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .vdd_on    (vdd_above_on),
    .vdd_off   (vdd_below_off),
    .line_ok   (line_ok),
    .high_line (high_line),
    .faults    (faults),
    .run       (run),
    .sw_en     (sw_en),
    .hv_src_en (hv_src_en)
  );

  // R6: undervoltage can only act once the startup blanking has elapsed
  a_r6_uv_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
    uv_hit |-> blank_done);

  // R9: an alarm seen while running leaves the run state on the next edge
  a_r9_alarm_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && (temp_hot || ocp_abn)) |=> !sw_en);

endmodule

// File: tb/fault_restart_seq_bench.sv
module fault_restart_seq_bench;
  localparam int VOVP = 8;
  localparam int OVN  = 3;
  localparam int UVN  = 3;
  localparam int UVB  = 40;
  localparam int BOW  = 30;
  localparam int BOR  = 3;
  localparam int HLL  = 3;
  localparam int HHL  = 6;

  logic clk, rst_n;
  logic vdd_above_on, vdd_below_off, vdd_over, cycle_end;
  logic out_ov_smp, out_uv_smp, line_ok, temp_hot, ocp_abn, high_line;
  logic sw_en, hv_src_en;

  int checks = 0;
  int errors = 0;

  fault_restart_seq #(
    .SUPPLY_OV_CYC(VOVP), .OUT_OV_CNT(OVN), .OUT_UV_CNT(UVN),
    .UV_BLANK_CYC(UVB), .BO_WINDOW_CYC(BOW), .BO_RECHECK_CNT(BOR),
    .HIC_LOW_LINE(HLL), .HIC_HIGH_LINE(HHL)
  ) u_fault_restart_seq (
    .clk(clk), .rst_n(rst_n), .vdd_above_on(vdd_above_on),
    .vdd_below_off(vdd_below_off), .vdd_over(vdd_over), .cycle_end(cycle_end),
    .out_ov_smp(out_ov_smp), .out_uv_smp(out_uv_smp), .line_ok(line_ok),
    .temp_hot(temp_hot), .ocp_abn(ocp_abn), .high_line(high_line),
    .sw_en(sw_en), .hv_src_en(hv_src_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic ov, input logic uv);
    cycle_end = 1'b1; out_ov_smp = ov; out_uv_smp = uv;
    step(1);
    cycle_end = 1'b0; out_ov_smp = 1'b0; out_uv_smp = 1'b0;
  endtask

  task automatic pulse_off();
    vdd_below_off = 1'b1; step(1); vdd_below_off = 1'b0;
  endtask

  task automatic pulse_on();
    vdd_above_on = 1'b1; step(1); vdd_above_on = 1'b0;
  endtask

  // from run or charging: fresh start into run
  task automatic bring_up();
    line_ok = 1'b1;
    pulse_off();
    pulse_on();
    step(1);
  endtask

  // from a fault: count turn-off crossings until switching resumes
  task automatic count_restarts(output int n);
    n = 0;
    line_ok = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      pulse_off();
      step(1);
      pulse_on();
      step(1);
      if (sw_en) begin
        n = k;
        return;
      end
    end
  endtask

  function automatic int exp_hic(input bit out_fault, input bit hl);
    if (!out_fault) return 1;
    return hl ? HHL : HLL;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    vdd_above_on = 0; vdd_below_off = 0; vdd_over = 0; cycle_end = 0;
    out_ov_smp = 0; out_uv_smp = 0; line_ok = 0; temp_hot = 0; ocp_abn = 0;
    high_line = 0;
    step(3);
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R1 hv_src_en in reset", hv_src_en, 1);
    rst_n = 1'b1;
    step(2);
    chk("R1 sw_en after reset", sw_en, 0);
    chk("R1 hv_src_en after reset", hv_src_en, 1);

    // R2 start-up
    line_ok = 1'b1;
    pulse_on();
    chk("R2 check state src", hv_src_en, 1);
    chk("R2 check state sw", sw_en, 0);
    step(1);
    chk("R2 running sw", sw_en, 1);
    chk("R2 running src", hv_src_en, 0);

    // R12 undervoltage lockout while running
    pulse_off();
    chk("R12 lockout sw", sw_en, 0);
    chk("R12 lockout src", hv_src_en, 1);
    pulse_on(); step(1);
    chk("R12 plain restart", sw_en, 1);

    // R4 supply overvoltage debounce
    vdd_over = 1'b1; step(VOVP - 1); vdd_over = 1'b0;
    chk("R4 short pulse ignored", sw_en, 1);
    step(2);
    vdd_over = 1'b1; step(VOVP - 1);
    chk("R4 before debounce end", sw_en, 1);
    step(1);
    chk("R4 tripped", sw_en, 0);
    vdd_over = 1'b0;
    count_restarts(n);
    chk("R8 supply OV one hiccup", n, 1);

    // R8 hiccup: source toggles without starting
    temp_hot = 1'b1; step(1); temp_hot = 1'b0;
    chk("R9 overtemp immediate", sw_en, 0);
    chk("R8 discharge src off", hv_src_en, 0);
    pulse_on();
    chk("R8 on ignored in discharge", hv_src_en, 0);
    count_restarts(n);
    chk("R8 overtemp one hiccup", n, 1);

    ocp_abn = 1'b1; step(1); ocp_abn = 1'b0;
    chk("R9 overcurrent immediate", sw_en, 0);
    count_restarts(n);
    chk("R8 overcurrent one hiccup", n, 1);

    // R3 brown-in failure
    pulse_off();
    line_ok = 1'b0;
    pulse_on(); step(1);
    chk("R3 brown-in fail sw", sw_en, 0);
    chk("R3 brown-in fail src", hv_src_en, 0);
    count_restarts(n);
    chk("R3 brown-in one hiccup", n, 1);

    // R5 output overvoltage count with reset in between
    bring_up();
    high_line = 1'b0;
    strobe(1, 0); strobe(1, 0); strobe(0, 0); strobe(1, 0); strobe(1, 0);
    chk("R5 count restarted", sw_en, 1);
    strobe(1, 0);
    chk("R5 tripped", sw_en, 0);
    count_restarts(n);
    chk("R7 low line budget", n, HLL);

    // R6 blanking then undervoltage, R7 high line captured at trip
    bring_up();
    for (int i = 0; i < 5; i++) strobe(0, 1);
    chk("R6 blanked", sw_en, 1);
    step(UVB);
    strobe(0, 1); strobe(0, 1);
    chk("R6 before count", sw_en, 1);
    high_line = 1'b1;
    strobe(0, 1);
    chk("R6 tripped", sw_en, 0);
    high_line = 1'b0;
    count_restarts(n);
    chk("R7 high line budget held", n, HHL);

    // R10 brown-out with strobes in window
    bring_up();
    line_ok = 1'b0;
    strobe(0, 0);
    step(BOW - 2);
    chk("R10 window not over", sw_en, 1);
    step(1);
    chk("R10 window trip", sw_en, 0);
    count_restarts(n);
    chk("R10 brown-out one hiccup", n, 1);

    // R10 window without strobes needs recheck
    bring_up();
    line_ok = 1'b0;
    step(BOW + 5);
    chk("R10 idle window no trip", sw_en, 1);
    strobe(0, 0); strobe(0, 0);
    chk("R10 recheck pending", sw_en, 1);
    strobe(0, 0);
    chk("R10 recheck trip", sw_en, 0);
    count_restarts(n);

    // R10 line recovery restarts the window
    bring_up();
    line_ok = 1'b0; strobe(0, 0); step(BOW - 3);
    line_ok = 1'b1; step(1);
    line_ok = 1'b0; strobe(0, 0); step(BOW - 3);
    chk("R10 recovery restarts window", sw_en, 1);
    line_ok = 1'b1;

    // R11 priority: overtemp beats output fault on the same edge
    bring_up();
    high_line = 1'b1;
    strobe(1, 0); strobe(1, 0);
    cycle_end = 1'b1; out_ov_smp = 1'b1; temp_hot = 1'b1;
    step(1);
    cycle_end = 1'b0; out_ov_smp = 1'b0; temp_hot = 1'b0;
    chk("R11 tripped", sw_en, 0);
    count_restarts(n);
    chk("R11 overtemp wins budget", n, 1);
    high_line = 1'b0;

    // randomised output-voltage patterns (R5, R6, R7)
    for (int t = 0; t < 24; t++) begin
      bit hl;
      int cov, cuv;
      bit tripped;
      hl = 1'($urandom % 2);
      high_line = hl;
      bring_up();
      step(UVB + 4);
      cov = 0; cuv = 0; tripped = 0;
      for (int s = 0; s < 40 && !tripped; s++) begin
        logic ov, uv;
        ov = ($urandom % 3) != 0;
        uv = ($urandom % 3) == 0;
        step($urandom % 3);
        strobe(ov, uv);
        cov = ov ? cov + 1 : 0;
        cuv = uv ? cuv + 1 : 0;
        tripped = (cov >= OVN) || (cuv >= UVN);
        chk("R5 R6 random sample", sw_en, tripped ? 0 : 1);
      end
      if (tripped) begin
        high_line = ~hl;
        count_restarts(n);
        chk("R7 random budget", n, exp_hic(1, hl));
      end else begin
        pulse_off();
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule